// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block fetches one instruction at a time from a byte-wide memory. It works alongside a program counter that lives outside the block. On a start request it reads the byte at the current counter address and keeps it as the opcode. From that opcode it decides how many more bytes belong to the instruction, and it reads them from the following addresses into operand registers. Each accepted byte raises an increment strobe so that the external counter steps forward.

Memory may stretch any read by holding its ready input low. The sequencer then waits in the same read, with the strobe still asserted, until ready returns. Once the last byte is in, the block raises a one-cycle valid pulse. The pulse comes with the opcode and both operand bytes, and execution logic downstream picks up the complete instruction there.

Top module: `fetch_seq`

## Requirements
- R1: After reset the block is idle: read strobe, increment strobe and valid are low, and opcode and both operand outputs are zero.
- R2: A start input seen while idle begins a fetch in the next cycle. While fetching, the read strobe is high and the memory address output equals the program counter input. No read is made in the valid cycle or while idle.
- R3: While the read strobe is high and ready is low, no byte is taken, the increment strobe stays low, the stored bytes do not change, and the same read is repeated in the next cycle.
- R4: The increment strobe is high exactly in those cycles where the read strobe and ready are both high. This gives one pulse per accepted byte, so after an instruction the counter has advanced by its length.
- R5: Instruction length comes from the opcode value: 0x00 to 0x3F gives 1 byte, 0x40 to 0x7F gives 2 bytes, and 0x80 to 0xFF gives 3 bytes.
- R6: The first byte of an instruction loads the opcode output, the second loads operand 0 and the third loads operand 1. When the opcode is taken, both operands are cleared, so operands the instruction does not use read as zero.
- R7: Valid is high for exactly one cycle: the cycle right after the last byte is accepted. The block is idle in the cycle after that.
- R8: Start is ignored while a fetch or a valid cycle is in progress. Holding start high across an instruction produces no extra read and no second valid pulse for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to fetch the next instruction |
| pc_i | input | ADDR_W | Current program counter value |
| pc_inc_o | output | 1 | Step the program counter by one |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | DATA_W | Byte returned by memory |
| mem_ready_i | input | 1 | Memory has the byte; low stretches the read |
| opcode_o | output | DATA_W | First instruction byte |
| opnd0_o | output | DATA_W | Second instruction byte, or zero |
| opnd1_o | output | DATA_W | Third instruction byte, or zero |
| valid_o | output | 1 | One-cycle pulse: instruction complete |

## Verification
The bench builds the block with ADDR_W = 10 and DATA_W = 8, and models a 1024-byte memory image that covers the whole address space. At that width an instruction placed at the top address wraps its later bytes to address zero. The image puts opcodes on each length boundary (0x3F, 0x40, 0x7F, 0x80, 0xFF) and fills the rest with a computed pattern. Ready is held fully high in some runs, broken by a pseudo-random pattern in others, and held low for a long stall, while start is either pulsed once or held high.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int MAX_LEN = 3;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_VALID = 2'd2
    } fetch_state_e;

    typedef struct packed {
        fetch_state_e     state;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
    } fetch_ctl_t;
endpackage

// File: rtl/fetch_len_dec.sv
module fetch_len_dec
    import fetch_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_i,
    output logic [LEN_W-1:0]  len_o
);
    // Two top opcode bits select the length class
    always_comb begin
        if (op_i[DATA_W-1])
            len_o = LEN_W'(3);
        else if (op_i[DATA_W-2])
            len_o = LEN_W'(2);
        else
            len_o = LEN_W'(1);
    end
endmodule

// File: rtl/fetch_byte_bank.sv
module fetch_byte_bank
    import fetch_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [LEN_W-1:0]             wr_idx_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output logic [MAX_LEN-1:0][DATA_W-1:0] bytes_o
);
    genvar g;
    generate
        for (g = 0; g < MAX_LEN; g++) begin : g_slot
            logic [DATA_W-1:0] slot_d, slot_q;

            always_comb begin
                slot_d = slot_q;
                if (wr_en_i && wr_idx_i == LEN_W'(g))
                    slot_d = wr_data_i;
                else if (g != 0 && wr_en_i && wr_idx_i == '0)
                    slot_d = '0;   // new opcode clears operands
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            assign bytes_o[g] = slot_q;
        end
    endgenerate
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              pc_inc_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              mem_ready_i,
    output logic [DATA_W-1:0] opcode_o,
    output logic [DATA_W-1:0] opnd0_o,
    output logic [DATA_W-1:0] opnd1_o,
    output logic              valid_o
);
    fetch_ctl_t       ctl_d, ctl_q;
    logic             take;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] total_len;
    logic [MAX_LEN-1:0][DATA_W-1:0] bytes;

    fetch_len_dec #(.DATA_W(DATA_W)) u_len (
        .op_i  (mem_data_i),
        .len_o (first_len)
    );

    always_comb begin
        ctl_d     = ctl_q;
        take      = 1'b0;
        total_len = (ctl_q.idx == '0) ? first_len : ctl_q.len;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_FETCH;
                    ctl_d.idx   = '0;
                end
            end
            ST_FETCH: begin
                if (mem_ready_i) begin
                    take = 1'b1;
                    if (ctl_q.idx == '0)
                        ctl_d.len = first_len;
                    if (ctl_q.idx == total_len - LEN_W'(1))
                        ctl_d.state = ST_VALID;
                    else
                        ctl_d.idx = ctl_q.idx + LEN_W'(1);
                end
            end
            ST_VALID: ctl_d.state = ST_IDLE;
            default:  ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, idx: '0, len: '0};
        else        ctl_q <= ctl_d;
    end

    fetch_byte_bank #(.DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (take),
        .wr_idx_i  (ctl_q.idx),
        .wr_data_i (mem_data_i),
        .bytes_o   (bytes)
    );

    assign mem_rd_o   = (ctl_q.state == ST_FETCH);
    assign mem_addr_o = pc_i;
    assign pc_inc_o   = take;
    assign valid_o    = (ctl_q.state == ST_VALID);
    assign opcode_o   = bytes[0];
    assign opnd0_o    = bytes[1];
    assign opnd1_o    = bytes[2];
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pc_inc_o,
    input logic              mem_rd_o,
    input logic              mem_ready_i,
    input logic              valid_o,
    input logic [DATA_W-1:0] opcode_o,
    input logic [DATA_W-1:0] opnd0_o,
    input logic [DATA_W-1:0] opnd1_o
);
    assert_inc_on_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o == (mem_rd_o && mem_ready_i));

    assert_stall_repeats_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ready_i) |=> mem_rd_o);

    assert_stall_keeps_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ready_i) |=> ($stable(opcode_o) && $stable(opnd0_o) && $stable(opnd1_o)));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!valid_o && !mem_rd_o));

    assert_valid_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(pc_inc_o));

    assert_no_read_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !mem_rd_o);
endmodule

bind fetch_seq fetch_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_inc_o    (pc_inc_o),
    .mem_rd_o    (mem_rd_o),
    .mem_ready_i (mem_ready_i),
    .valid_o     (valid_o),
    .opcode_o    (opcode_o),
    .opnd0_o     (opnd0_o),
    .opnd1_o     (opnd1_o)
);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int MEM_N = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic          pc_inc_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rd_o;
    logic [DW-1:0] mem_data_i = '0;
    logic          mem_ready_i = 1'b1;
    logic [DW-1:0] opcode_o, opnd0_o, opnd1_o;
    logic          valid_o;

    always #10 clk = ~clk;   // 50 MHz

    fetch_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i),
        .pc_inc_o(pc_inc_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .mem_data_i(mem_data_i), .mem_ready_i(mem_ready_i),
        .opcode_o(opcode_o), .opnd0_o(opnd0_o), .opnd1_o(opnd1_o),
        .valid_o(valid_o)
    );

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] mem [MEM_N];

    // reference model state: 0 idle, 1 fetching, 2 valid
    int            m_state = 0;
    int            m_idx = 0;
    int            m_len = 0;
    logic [DW-1:0] m_op = '0, m_o0 = '0, m_o1 = '0;
    logic [AW-1:0] m_pc = '0;
    int            valid_seen = 0;
    logic [31:0]   lfsr = 32'h1ace_b00c;

    function automatic int len_of(input logic [DW-1:0] op);
        if (op >= 8'h80) return 3;
        if (op >= 8'h40) return 2;
        return 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare against model, advance model
    task automatic cycle(input logic st, input logic rdy);
        bit exp_rd, exp_inc;
        int tot;
        @(negedge clk);
        pc_i        = m_pc;
        start_i     = st;
        mem_ready_i = rdy;
        mem_data_i  = mem[m_pc];
        #1;
        exp_rd  = (m_state == 1);
        exp_inc = exp_rd && rdy;
        chk(st ? "R8" : "R2", "mem_rd", mem_rd_o, exp_rd);
        if (exp_rd) chk("R2", "mem_addr", mem_addr_o, m_pc);
        chk((exp_rd && !rdy) ? "R3" : "R4", "pc_inc", pc_inc_o, exp_inc);
        chk("R7", "valid", valid_o, m_state == 2);
        chk("R6", "opcode", opcode_o, m_op);
        chk("R6", "opnd0", opnd0_o, m_o0);
        chk("R6", "opnd1", opnd1_o, m_o1);
        if (valid_o) valid_seen++;
        case (m_state)
            0: if (st) begin m_state = 1; m_idx = 0; end
            1: if (rdy) begin
                if (m_idx == 0) begin
                    m_op = mem_data_i; m_o0 = '0; m_o1 = '0;
                    m_len = len_of(mem_data_i);
                end else if (m_idx == 1) m_o0 = mem_data_i;
                else m_o1 = mem_data_i;
                tot = m_len;
                m_pc = m_pc + 1'b1;
                if (m_idx + 1 == tot) m_state = 2;
                else m_idx++;
            end
            default: m_state = 0;
        endcase
    endtask

    function automatic logic next_rdy(input int mode);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (mode == 0) return 1'b1;
        return lfsr[3] | lfsr[7];
    endfunction

    // mode 0 all ready, 1 random stalls, 2 long stall at every byte
    task automatic run_instr(input int mode, input bit hold_start);
        logic [AW-1:0] pc0;
        int exp_len, v0, n;
        pc0 = m_pc;
        exp_len = len_of(mem[pc0]);
        v0 = valid_seen;
        cycle(1'b1, 1'b1);
        n = 0;
        while (m_state != 0 && n < 200) begin
            if (mode == 2 && m_state == 1) begin
                for (int k = 0; k < 9; k++) cycle(hold_start, 1'b0);
                cycle(hold_start, 1'b1);
            end else begin
                cycle(hold_start, next_rdy(mode));
            end
            n++;
        end
        cycle(1'b0, 1'b1);  // back in idle, outputs still held
        chk("R5", "pc advance", int'(AW'(m_pc - pc0)), exp_len);
        chk("R8", "valid pulses", valid_seen - v0, 1);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = DW'(i * 37 + 5);
        mem[0] = 8'h12;
        mem[1] = 8'h55; mem[2] = 8'hA1;
        mem[3] = 8'h9C; mem[4] = 8'h34; mem[5] = 8'h56;
        mem[6] = 8'h3F;
        mem[7] = 8'h40; mem[8] = 8'hFF;
        mem[9] = 8'h7F; mem[10] = 8'h00;
        mem[11] = 8'h80; mem[12] = 8'h11; mem[13] = 8'h22;
        mem[14] = 8'hFF; mem[15] = 8'h00; mem[16] = 8'hEE;
        mem[17] = 8'h00;
        mem[MEM_N-1] = 8'hC3; mem[0] = 8'h12;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rd in reset", mem_rd_o, 0);
        chk("R1", "valid in reset", valid_o, 0);
        chk("R1", "inc in reset", pc_inc_o, 0);
        chk("R1", "opcode in reset", opcode_o, 0);
        chk("R1", "opnds in reset", {opnd0_o, opnd1_o}, 0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);

        for (int i = 0; i < 8; i++) run_instr(0, 1'b0);   // all length boundaries
        m_pc = '0;
        for (int i = 0; i < 8; i++) run_instr(1, 1'b1);   // stalls, start held (R8)
        m_pc = '0;
        for (int i = 0; i < 3; i++) run_instr(2, 1'b0);   // long stalls (R3)
        m_pc = AW'(MEM_N - 1);
        run_instr(1, 1'b0);                               // wrap across top address
        m_pc = AW'(40);
        for (int i = 0; i < 60; i++) run_instr(i % 3, i[2]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule